// File: doc/BRIEF.md
# Prioritized Memory Chip-Select Decoder

This block turns a 16-bit microcontroller address and its access strobes into chip selects for three kinds of memory: eight primary flash sectors, four secondary flash sectors and one SRAM. Each select owns an inclusive address window, fixed by parameters. Windows of different kinds may overlap. When they do, a fixed ranking settles the access. SRAM ranks first, secondary flash second and primary flash last. The lower-ranked memory loses the shared addresses without any warning.

A six-bit mapping register states, for each memory kind, whether it answers program fetches, data reads, or both. It resets to a parameter value. Software can rewrite it by a bus write to one dedicated address, which lets memories trade places between the program and data spaces at run time. All selects are combinational in the address and the strobes. Only the mapping register holds state.

Top module: `mcs_decoder`

## Requirements
- R1: An address inside the SRAM window, during an access whose space holds SRAM, raises only `ram_sel_o`, even when flash windows also cover it.
- R2: An address inside both a secondary and a primary flash window, with secondary flash present in the active space and no SRAM claim, raises only the secondary select.
- R3: With primary sector 0 at 8000h–BFFFh, secondary sector 0 at 8000h–9FFFh and SRAM at 8000h–87FFh, all three in the active space: 8000h–87FFh selects SRAM, 8800h–9FFFh selects secondary sector 0, and A000h–BFFFh selects primary sector 0.
- R4: `psen_i` high makes the access a program access. `rd_i` high with `psen_i` low makes it a data access. When both are high, program space wins. With neither high, every select and `cfg_err_o` are low.
- R5: A memory kind that is not placed in the active space never claims an address. A lower-ranked memory that is placed there may then take the address.
- R6: The mapping register bits are: bit 0 SRAM in program space, bit 1 SRAM in data space, bit 2 primary flash in program space, bit 3 primary flash in data space, bit 4 secondary flash in program space, bit 5 secondary flash in data space. The reset value is 1Bh: SRAM in both spaces, primary flash in data space only, secondary flash in program space only.
- R7: A cycle with `wr_i` high and `addr_i` equal to `MAP_ADDR` (default 6F00h) loads `wdata_i[5:0]` into the mapping register at that clock edge. The new value governs decoding from the next cycle. A write to any other address leaves the register unchanged.
- R8: A window's upper bound is cut to base + 16 KB − 1 for primary sectors and to base + 8 KB − 1 for secondary sectors. In the defaults, primary sector 7 asks for 2800h–7FFFh and answers on 2800h–67FFh. Secondary sector 3 asks for 4000h–7FFFh and answers on 4000h–5FFFh.
- R9: When an address hits two or more enabled windows of one flash kind placed in the active space, `cfg_err_o` rises and only the lowest-indexed of those sectors is selected.
- R10: At most one select output is high in any cycle. If no window matches, or no matching memory is placed in the active space, all selects are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the mapping register |
| rst_ni | input | 1 | Active-low reset; loads the mapping register with MAP_INIT |
| addr_i | input | 16 | Processor address |
| psen_i | input | 1 | Program-fetch strobe, active high |
| rd_i | input | 1 | Data read strobe, active high |
| wr_i | input | 1 | Write strobe; used only to load the mapping register |
| wdata_i | input | 8 | Write data; bits 5:0 go to the mapping register |
| pfs_o | output | 8 | Primary flash sector selects, one-hot or zero |
| sfs_o | output | 4 | Secondary flash sector selects, one-hot or zero |
| ram_sel_o | output | 1 | SRAM select |
| cfg_err_o | output | 1 | Same-level window overlap hit during an access |

## Verification
The assertions assume the strobes and the write pulse are clean, single-cycle-sampled levels. They also assume the register write address is compared on the same cycle that `wr_i` is high. They do not require `psen_i` and `rd_i` to be exclusive, because the block defines what happens when both are high. The random stimulus draws any address and any strobe combination, including both strobes together. Writes to the mapping register are occasional, usually at the register address and sometimes elsewhere. A second instance is given deliberately overlapping primary windows, so the error path is driven without breaking the legal layout of the main instance.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_PROG = 2'd1,
        SP_DATA = 2'd2
    } space_e;

    localparam int MAP_W     = 6;
    localparam int MB_RAM_P  = 0;
    localparam int MB_RAM_D  = 1;
    localparam int MB_PRI_P  = 2;
    localparam int MB_PRI_D  = 3;
    localparam int MB_SEC_P  = 4;
    localparam int MB_SEC_D  = 5;

    function automatic space_e space_of(input logic psen, input logic rd);
        if (psen)    return SP_PROG;
        else if (rd) return SP_DATA;
        else         return SP_IDLE;
    endfunction

    function automatic logic placed(input space_e sp, input logic in_prog, input logic in_data);
        return ((sp == SP_PROG) && in_prog) || ((sp == SP_DATA) && in_data);
    endfunction

endpackage

// File: rtl/mcs_window.sv
module mcs_window #(
    parameter int              AW     = 16,
    parameter int              MAX_SZ = 16384,
    parameter logic [AW-1:0]   BASE   = '0,
    parameter logic [AW-1:0]   LIMIT  = '0,
    parameter bit              EN     = 1'b1
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    localparam logic [AW:0] CAP   = {1'b0, BASE} + (AW+1)'(MAX_SZ - 1);
    localparam logic [AW:0] EFF   = ({1'b0, LIMIT} < CAP) ? {1'b0, LIMIT} : CAP;
    localparam logic [AW:0] SPAN  = EFF - {1'b0, BASE};
    localparam bit          VALID = EN && (LIMIT >= BASE);

    logic [AW:0] offs;

    always_comb begin
        offs  = {1'b0, addr_i} - {1'b0, BASE};
        hit_o = VALID && !offs[AW] && (offs <= SPAN);
    end
endmodule

// File: rtl/mcs_prio.sv
module mcs_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o,
    output logic         multi_o
);
    logic [N-1:0] below;

    assign below[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign below[i] = below[i-1] | req_i[i-1];
    end

    assign gnt_o   = req_i & ~below;
    assign any_o   = |req_i;
    assign multi_o = |(req_i & below);
endmodule

// File: rtl/mcs_map_reg.sv
module mcs_map_reg
    import mcs_pkg::*;
#(
    parameter int                AW       = 16,
    parameter int                DW       = 8,
    parameter logic [AW-1:0]     MAP_ADDR = 16'h6F00,
    parameter logic [MAP_W-1:0]  MAP_INIT = 6'h1B
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [MAP_W-1:0] map_o
);
    logic             load;
    logic [MAP_W-1:0] map_q;

    assign load = wr_i && (addr_i == MAP_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   map_q <= MAP_INIT;
        else if (load) map_q <= wdata_i[MAP_W-1:0];
    end

    assign map_o = map_q;
endmodule

// File: rtl/mcs_decoder.sv
module mcs_decoder
    import mcs_pkg::*;
#(
    parameter int                    AW        = 16,
    parameter int                    DW        = 8,
    parameter int                    N_PRI     = 8,
    parameter int                    N_SEC     = 4,
    parameter int                    PRI_MAX   = 16384,
    parameter int                    SEC_MAX   = 8192,
    parameter logic [N_PRI*AW-1:0]   PRI_BASE  = {16'h2800, 16'h2000, 16'h1800, 16'h1000,
                                                  16'h0800, 16'h0000, 16'hC000, 16'h8000},
    parameter logic [N_PRI*AW-1:0]   PRI_LIMIT = {16'h7FFF, 16'h27FF, 16'h1FFF, 16'h17FF,
                                                  16'h0FFF, 16'h07FF, 16'hFFFF, 16'hBFFF},
    parameter logic [N_PRI-1:0]      PRI_EN    = '1,
    parameter logic [N_SEC*AW-1:0]   SEC_BASE  = {16'h4000, 16'hC000, 16'h0000, 16'h8000},
    parameter logic [N_SEC*AW-1:0]   SEC_LIMIT = {16'h7FFF, 16'hDFFF, 16'h07FF, 16'h9FFF},
    parameter logic [N_SEC-1:0]      SEC_EN    = '1,
    parameter logic [AW-1:0]         RAM_BASE  = 16'h8000,
    parameter logic [AW-1:0]         RAM_LIMIT = 16'h87FF,
    parameter bit                    RAM_EN    = 1'b1,
    parameter logic [AW-1:0]         MAP_ADDR  = 16'h6F00,
    parameter logic [MAP_W-1:0]      MAP_INIT  = 6'h1B
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [AW-1:0]    addr_i,
    input  logic             psen_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [N_PRI-1:0] pfs_o,
    output logic [N_SEC-1:0] sfs_o,
    output logic             ram_sel_o,
    output logic             cfg_err_o
);
    localparam int RAM_MAX = 1 << AW;

    logic [MAP_W-1:0] map_q;
    space_e           space;
    logic             ram_ok, pri_ok, sec_ok;

    logic [N_PRI-1:0] pri_raw, pri_req, pri_gnt;
    logic [N_SEC-1:0] sec_raw, sec_req, sec_gnt;
    logic             ram_raw, ram_req;
    logic             pri_any, pri_multi, sec_any, sec_multi;

    mcs_map_reg #(
        .AW(AW), .DW(DW), .MAP_ADDR(MAP_ADDR), .MAP_INIT(MAP_INIT)
    ) u_map (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
        .wr_i(wr_i), .wdata_i(wdata_i), .map_o(map_q)
    );

    for (genvar i = 0; i < N_PRI; i++) begin : g_pri
        mcs_window #(
            .AW(AW), .MAX_SZ(PRI_MAX),
            .BASE(PRI_BASE[i*AW +: AW]), .LIMIT(PRI_LIMIT[i*AW +: AW]), .EN(PRI_EN[i])
        ) u_win (.addr_i(addr_i), .hit_o(pri_raw[i]));
    end

    for (genvar j = 0; j < N_SEC; j++) begin : g_sec
        mcs_window #(
            .AW(AW), .MAX_SZ(SEC_MAX),
            .BASE(SEC_BASE[j*AW +: AW]), .LIMIT(SEC_LIMIT[j*AW +: AW]), .EN(SEC_EN[j])
        ) u_win (.addr_i(addr_i), .hit_o(sec_raw[j]));
    end

    mcs_window #(
        .AW(AW), .MAX_SZ(RAM_MAX), .BASE(RAM_BASE), .LIMIT(RAM_LIMIT), .EN(RAM_EN)
    ) u_ram_win (.addr_i(addr_i), .hit_o(ram_raw));

    always_comb begin
        space  = space_of(psen_i, rd_i);
        ram_ok = placed(space, map_q[MB_RAM_P], map_q[MB_RAM_D]);
        pri_ok = placed(space, map_q[MB_PRI_P], map_q[MB_PRI_D]);
        sec_ok = placed(space, map_q[MB_SEC_P], map_q[MB_SEC_D]);
        ram_req = ram_raw & ram_ok;
        pri_req = pri_raw & {N_PRI{pri_ok}};
        sec_req = sec_raw & {N_SEC{sec_ok}};
    end

    mcs_prio #(.N(N_PRI)) u_pri_prio (
        .req_i(pri_req), .gnt_o(pri_gnt), .any_o(pri_any), .multi_o(pri_multi)
    );

    mcs_prio #(.N(N_SEC)) u_sec_prio (
        .req_i(sec_req), .gnt_o(sec_gnt), .any_o(sec_any), .multi_o(sec_multi)
    );

    always_comb begin
        ram_sel_o = ram_req;
        sfs_o     = ram_req ? '0 : sec_gnt;
        pfs_o     = (ram_req || sec_any) ? '0 : pri_gnt;
        cfg_err_o = (space != SP_IDLE) && (pri_multi || sec_multi);
    end

    logic unused_any;
    assign unused_any = pri_any;
endmodule

// File: rtl/mcs_decoder_chk.sv
module mcs_decoder_chk #(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter int            N_PRI    = 8,
    parameter int            N_SEC    = 4,
    parameter logic [AW-1:0] MAP_ADDR = 16'h6F00
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [AW-1:0]    addr_i,
    input logic             psen_i,
    input logic             rd_i,
    input logic             wr_i,
    input logic [DW-1:0]    wdata_i,
    input logic [N_PRI-1:0] pfs_o,
    input logic [N_SEC-1:0] sfs_o,
    input logic             ram_sel_o,
    input logic             cfg_err_o,
    input logic [5:0]       map_q
);
    assert_one_select_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({pfs_o, sfs_o, ram_sel_o}) <= 1);

    assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!psen_i && !rd_i) |-> (pfs_o == '0 && sfs_o == '0 && !ram_sel_o && !cfg_err_o));

    assert_ram_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ram_sel_o |-> (pfs_o == '0 && sfs_o == '0));

    assert_sec_beats_pri_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sfs_o != '0) |-> (pfs_o == '0));

    assert_map_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == MAP_ADDR) |=> (map_q == $past(wdata_i[5:0])));

    assert_map_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && addr_i == MAP_ADDR) |=> $stable(map_q));

    assert_err_needs_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (psen_i || rd_i));
endmodule

bind mcs_decoder mcs_decoder_chk #(
    .AW(AW), .DW(DW), .N_PRI(N_PRI), .N_SEC(N_SEC), .MAP_ADDR(MAP_ADDR)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .psen_i(psen_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .pfs_o(pfs_o), .sfs_o(sfs_o),
    .ram_sel_o(ram_sel_o), .cfg_err_o(cfg_err_o), .map_q(map_q)
);

// File: tb/sim_mcs_decoder.sv
module sim_mcs_decoder;
    localparam logic [15:0]  MAP_ADDR = 16'h6F00;
    localparam logic [127:0] T_PB = {16'h2800, 16'h2000, 16'h1800, 16'h1000,
                                     16'h0800, 16'h0000, 16'hC000, 16'h8000};
    localparam logic [127:0] T_PL = {16'h7FFF, 16'h27FF, 16'h1FFF, 16'h17FF,
                                     16'h0FFF, 16'h07FF, 16'hFFFF, 16'hBFFF};
    localparam logic [63:0]  T_SB = {16'h4000, 16'hC000, 16'h0000, 16'h8000};
    localparam logic [63:0]  T_SL = {16'h7FFF, 16'hDFFF, 16'h07FF, 16'h9FFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        psen = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  pfs;
    logic [3:0]  sfs;
    logic        ram_sel, cfg_err;

    logic [15:0] addr1 = '0;
    logic        psen1 = 1'b0, rd1 = 1'b0;
    logic [7:0]  pfs1;
    logic [3:0]  sfs1;
    logic        ram1, err1;

    int          n_chk = 0, n_fail = 0;
    logic [5:0]  mmap = 6'h1B;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mcs_decoder u0 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .psen_i(psen), .rd_i(rd),
        .wr_i(wr), .wdata_i(wdata), .pfs_o(pfs), .sfs_o(sfs),
        .ram_sel_o(ram_sel), .cfg_err_o(cfg_err)
    );

    mcs_decoder #(
        .PRI_BASE ({96'h0, 16'hA000, 16'h8000}),
        .PRI_LIMIT({96'h0, 16'hAFFF, 16'hBFFF}),
        .PRI_EN(8'h03), .SEC_EN(4'h0), .RAM_EN(1'b0)
    ) u1 (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr1), .psen_i(psen1), .rd_i(rd1),
        .wr_i(1'b0), .wdata_i(8'h00), .pfs_o(pfs1), .sfs_o(sfs1),
        .ram_sel_o(ram1), .cfg_err_o(err1)
    );

    function automatic logic [13:0] pack(input logic e, input logic r,
                                         input logic [3:0] s, input logic [7:0] p);
        return {e, r, s, p};
    endfunction

    function automatic logic [13:0] model(input logic [15:0] a, input logic ps,
                                          input logic r, input logic [5:0] m);
        logic prog, data, okr, okp, oks, rh;
        logic [7:0] ph, pg;
        logic [3:0] sh, sg;
        int np, ns, top;
        prog = ps;
        data = !ps && r;
        okr = (prog && m[0]) || (data && m[1]);
        okp = (prog && m[2]) || (data && m[3]);
        oks = (prog && m[4]) || (data && m[5]);
        ph = '0; sh = '0; pg = '0; sg = '0; np = 0; ns = 0;
        for (int i = 0; i < 8; i++) begin
            top = int'(T_PL[i*16 +: 16]);
            if (int'(T_PB[i*16 +: 16]) + 16383 < top) top = int'(T_PB[i*16 +: 16]) + 16383;
            if (okp && int'(a) >= int'(T_PB[i*16 +: 16]) && int'(a) <= top) begin
                ph[i] = 1'b1;
                if (np == 0) pg[i] = 1'b1;
                np++;
            end
        end
        for (int i = 0; i < 4; i++) begin
            top = int'(T_SL[i*16 +: 16]);
            if (int'(T_SB[i*16 +: 16]) + 8191 < top) top = int'(T_SB[i*16 +: 16]) + 8191;
            if (oks && int'(a) >= int'(T_SB[i*16 +: 16]) && int'(a) <= top) begin
                sh[i] = 1'b1;
                if (ns == 0) sg[i] = 1'b1;
                ns++;
            end
        end
        rh = okr && a >= 16'h8000 && a <= 16'h87FF;
        if (rh) return pack(np > 1 || ns > 1, 1'b1, 4'h0, 8'h00);
        if (sh != 0) return pack(np > 1 || ns > 1, 1'b0, sg, 8'h00);
        return pack(np > 1 || ns > 1, 1'b0, 4'h0, pg);
    endfunction

    task automatic chk(input string rq, input logic [13:0] act, input logic [13:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic ps, input logic r,
                        input logic w, input logic [7:0] d,
                        input string rq, input logic [13:0] exp);
        @(negedge clk);
        addr = a; psen = ps; rd = r; wr = w; wdata = d;
        #1;
        chk(rq, {cfg_err, ram_sel, sfs, pfs}, exp);
        @(posedge clk);
        if (w && a == MAP_ADDR) mmap = d[5:0];
    endtask

    task automatic acc(input logic [15:0] a, input logic ps, input logic r,
                       input string rq, input logic [13:0] exp);
        step(a, ps, r, 1'b0, 8'h00, rq, exp);
    endtask

    task automatic setmap(input logic [5:0] m);
        step(MAP_ADDR, 1'b0, 1'b0, 1'b1, {2'b00, m}, "R7 write cycle", 14'h0);
    endtask

    task automatic chk1(input logic [15:0] a, input logic ps, input logic r,
                        input string rq, input logic [13:0] exp);
        @(negedge clk);
        addr1 = a; psen1 = ps; rd1 = r;
        #1;
        chk(rq, {err1, ram1, sfs1, pfs1}, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state: no strobe, nothing selected
        acc(16'h8000, 0, 0, "R10 reset idle", 14'h0);
        // R6 reset map: SRAM both, primary data, secondary program
        acc(16'h8000, 0, 1, "R1 R6 rd sram",  pack(0, 1, 4'h0, 8'h00));
        acc(16'h8000, 1, 0, "R1 R6 psen sram", pack(0, 1, 4'h0, 8'h00));
        acc(16'h8800, 0, 1, "R5 R6 rd sec absent", pack(0, 0, 4'h0, 8'h01));
        acc(16'h8800, 1, 0, "R2 R6 psen sec", pack(0, 0, 4'h1, 8'h00));
        acc(16'hA000, 1, 0, "R6 psen pri absent", 14'h0);
        acc(16'hA000, 0, 0, "R4 no strobe", 14'h0);

        setmap(6'h3F);
        // R3 worked case edges
        acc(16'h8000, 0, 1, "R3 8000", pack(0, 1, 4'h0, 8'h00));
        acc(16'h87FF, 0, 1, "R3 87FF", pack(0, 1, 4'h0, 8'h00));
        acc(16'h8800, 0, 1, "R3 8800", pack(0, 0, 4'h1, 8'h00));
        acc(16'h9FFF, 0, 1, "R3 9FFF", pack(0, 0, 4'h1, 8'h00));
        acc(16'hA000, 0, 1, "R3 A000", pack(0, 0, 4'h0, 8'h01));
        acc(16'hBFFF, 1, 0, "R3 BFFF", pack(0, 0, 4'h0, 8'h01));
        acc(16'hC000, 0, 1, "R2 C000", pack(0, 0, 4'h4, 8'h00));
        acc(16'hE000, 0, 1, "R2 E000 pri only", pack(0, 0, 4'h0, 8'h02));
        // R8 size clamps
        acc(16'h5FFF, 0, 1, "R8 sec3 top", pack(0, 0, 4'h8, 8'h00));
        acc(16'h6000, 0, 1, "R8 sec3 clamp", pack(0, 0, 4'h0, 8'h80));
        acc(16'h67FF, 0, 1, "R8 pri7 top", pack(0, 0, 4'h0, 8'h80));
        acc(16'h6800, 0, 1, "R8 pri7 clamp", 14'h0);

        // R7 write elsewhere ignored
        step(MAP_ADDR + 16'h1, 1'b0, 1'b0, 1'b1, 8'h00, "R7 stray write", 14'h0);
        acc(16'h8800, 0, 1, "R7 map kept", pack(0, 0, 4'h1, 8'h00));

        setmap(6'h01);
        acc(16'h8000, 1, 1, "R4 psen wins", pack(0, 1, 4'h0, 8'h00));
        acc(16'h8000, 0, 1, "R5 sram not data", 14'h0);
        acc(16'h8800, 1, 0, "R10 no memory placed", 14'h0);

        setmap(6'h08);
        acc(16'h8000, 0, 1, "R5 primary takes", pack(0, 0, 4'h0, 8'h01));
        acc(16'h8000, 1, 0, "R7 new map next cycle", 14'h0);

        // R9 overlapping primary windows in the second instance
        chk1(16'hA100, 0, 1, "R9 overlap err", pack(1, 0, 4'h0, 8'h01));
        chk1(16'h9000, 0, 1, "R9 single hit", pack(0, 0, 4'h0, 8'h01));
        chk1(16'hA100, 1, 0, "R9 not placed", 14'h0);
        chk1(16'hA100, 0, 0, "R9 idle", 14'h0);

        // random mix against the bench model
        for (int k = 0; k < 1500; k++) begin
            logic [15:0] a;
            logic ps, r, w;
            logic [7:0] d;
            a  = 16'($urandom);
            ps = ($urandom % 3) == 0;
            r  = ($urandom % 2) == 0;
            w  = 1'b0;
            d  = 8'($urandom);
            if (($urandom % 12) == 0) begin
                w = 1'b1;
                if (($urandom % 4) != 0) a = MAP_ADDR;
            end
            step(a, ps, r, w, d, "R10 random", model(a, ps, r, mmap));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule